// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Generator

This block turns a stream of source ticks into a slower stream of single-cycle clock-enable pulses. The source ticks are enable inputs, one for each candidate source clock domain; a select field picks which one counts. A half-integer pre-divider thins the chosen stream first. An optional M/N fractional stage then keeps, on average, M of every N pre-divided ticks. A second output level, shaped by a D threshold, gives the pulse train a programmable duty.

The configuration fields come from a register block in the encoded form that software writes. N and D are not stored directly. The N field holds the low bits of the bitwise inverse of (N - M), and the D field holds the low bits of the bitwise inverse of D. A one-cycle load strobe copies all fields into the active set and restarts both counters from zero. The pulse rate is then deterministic from that point, which lets downstream logic time its work against it.

Top module: `fmn_clken_gen`

## Requirements
- R1: Reset drives tick_out and duty_out low. It clears the active configuration to source 0, pre-divider 0 and M/N mode 0.
- R2: Only the enable bit at index cfg_src_sel of src_en counts as a source tick. The other bits have no effect on either output.
- R3: With the pre-divider field at 0, every source tick is passed on as a pre-divided tick.
- R4: With a nonzero pre-divider field P, K source ticks after a load give floor(2K/(P+1)) pre-divided ticks. No source tick ever gives more than one.
- R5: The true N is recovered as ((~cfg_n_code) masked to MN_W bits) + cfg_m, truncated to MN_W bits.
- R6: The M/N stage is active when cfg_mode is nonzero, the true N is nonzero, and M < N. While it is active, Q pre-divided ticks after a load give floor(Q*M/N) output pulses.
- R7: When cfg_mode is 0, or the true N is 0, or M >= N, the M/N stage is bypassed. Every pre-divided tick then becomes an output pulse.
- R8: The true D is (~cfg_d_code) masked to MN_W bits. While the M/N stage is active, duty_out is high exactly when the stage's running remainder is below D. In bypass, duty_out equals tick_out.
- R9: A cycle with cfg_load high captures the fields and zeroes both counters. tick_out is low in the following cycle, even if a source tick arrives together with the load.
- R10: A qualifying source tick at clock edge t shows as tick_out high for exactly the cycle after edge t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | NUM_SRC | One tick-enable per candidate source |
| cfg_load | input | 1 | Copy configuration fields into the active set and restart |
| cfg_src_sel | input | SEL_W | Index of the source that counts |
| cfg_pre_div | input | PD_W | Half-integer pre-divider field, 0 = bypass |
| cfg_mode | input | 2 | Nonzero enables the M/N stage |
| cfg_m | input | MN_W | M value |
| cfg_n_code | input | MN_W | Inverted (N - M) |
| cfg_d_code | input | MN_W | Inverted D |
| tick_out | output | 1 | Single-cycle output enable pulse |
| duty_out | output | 1 | Duty-shaped level |

## Verification
The bench builds the block with eight sources, a 3-bit pre-divider and a 4-bit M/N width. At this size it can sweep every source index against every pre-divider value. It can also sweep every M against every true N from 1 to 15, which includes each M >= N bypass case. Pulse counts are checked against the floor formulas, starting from a fresh load. Directed cases cover a true N that decodes to zero, mode 0 with a valid ratio, a load that coincides with a source tick, and a step-by-step trace of the duty threshold.

// File: rtl/fmn_pkg.sv
`timescale 1ns/1ps
package fmn_pkg;

    localparam int unsigned FMN_MODE_W   = 2;
    localparam int unsigned FMN_SRC_DEF  = 8;
    localparam int unsigned FMN_PD_W_DEF = 5;
    localparam int unsigned FMN_MN_W_DEF = 8;

    // Per-cycle status of the fractional stage
    typedef struct packed {
        logic pulse;
        logic duty;
        logic active;
    } mn_status_t;

    // Low w bits of the bitwise inverse of raw
    function automatic logic [31:0] inv_field(input logic [31:0] raw, input int unsigned w);
        logic [31:0] mask;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return (~raw) & mask;
    endfunction

endpackage

// File: rtl/fmn_src_pick.sv
`timescale 1ns/1ps
module fmn_src_pick #(
    parameter int unsigned NUM_SRC = fmn_pkg::FMN_SRC_DEF,
    localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit
);
    logic [NUM_SRC-1:0] match;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_match
        assign match[g] = src_en[g] && (sel == SEL_W'(g));
    end

    assign hit = |match;
endmodule

// File: rtl/fmn_prediv.sv
`timescale 1ns/1ps
module fmn_prediv #(
    parameter int unsigned PD_W = fmn_pkg::FMN_PD_W_DEF,
    localparam int unsigned AW  = PD_W + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            tick_in,
    input  logic [PD_W-1:0] div,
    output logic            tick_out,
    output logic [AW-1:0]   acc_o
);
    logic [AW-1:0] acc_q;
    logic [AW-1:0] thr;
    logic [AW-1:0] sum;
    logic          reach;
    logic          bypass;

    always_comb begin
        bypass = (div == '0);
        thr    = {2'b00, div} + AW'(1);
        sum    = acc_q + AW'(2);
        reach  = (sum >= thr);
        tick_out = bypass ? tick_in : (tick_in && reach);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || bypass) begin
            acc_q <= '0;
        end else if (tick_in) begin
            acc_q <= reach ? (sum - thr) : sum;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/fmn_mn_stage.sv
`timescale 1ns/1ps
module fmn_mn_stage #(
    parameter int unsigned MN_W = fmn_pkg::FMN_MN_W_DEF,
    localparam int unsigned AW  = MN_W + 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            tick_in,
    input  logic [fmn_pkg::FMN_MODE_W-1:0]  mode,
    input  logic [MN_W-1:0]                 m_val,
    input  logic [MN_W-1:0]                 n_code,
    input  logic [MN_W-1:0]                 d_code,
    output fmn_pkg::mn_status_t             status,
    output logic [AW-1:0]                   acc_o,
    output logic [MN_W-1:0]                 n_dec_o
);
    logic [MN_W-1:0] n_dec;
    logic [MN_W-1:0] d_dec;
    logic [AW-1:0]   acc_q;
    logic [AW-1:0]   sum;
    logic            reach;
    logic            active;

    always_comb begin
        n_dec  = MN_W'(fmn_pkg::inv_field(32'(n_code), MN_W) + 32'(m_val));
        d_dec  = MN_W'(fmn_pkg::inv_field(32'(d_code), MN_W));
        active = (mode != '0) && (n_dec != '0) && (m_val < n_dec);
        sum    = acc_q + {1'b0, m_val};
        reach  = (sum >= {1'b0, n_dec});
        status.active = active;
        status.pulse  = active ? (tick_in && reach) : tick_in;
        status.duty   = (acc_q < {1'b0, d_dec});
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !active) begin
            acc_q <= '0;
        end else if (tick_in) begin
            acc_q <= reach ? (sum - {1'b0, n_dec}) : sum;
        end
    end

    assign acc_o   = acc_q;
    assign n_dec_o = n_dec;
endmodule

// File: rtl/fmn_clken_gen.sv
`timescale 1ns/1ps
module fmn_clken_gen #(
    parameter int unsigned NUM_SRC = fmn_pkg::FMN_SRC_DEF,
    parameter int unsigned PD_W    = fmn_pkg::FMN_PD_W_DEF,
    parameter int unsigned MN_W    = fmn_pkg::FMN_MN_W_DEF,
    localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_SRC-1:0]                 src_en,
    input  logic                               cfg_load,
    input  logic [SEL_W-1:0]                   cfg_src_sel,
    input  logic [PD_W-1:0]                    cfg_pre_div,
    input  logic [fmn_pkg::FMN_MODE_W-1:0]     cfg_mode,
    input  logic [MN_W-1:0]                    cfg_m,
    input  logic [MN_W-1:0]                    cfg_n_code,
    input  logic [MN_W-1:0]                    cfg_d_code,
    output logic                               tick_out,
    output logic                               duty_out
);
    typedef struct packed {
        logic [SEL_W-1:0]               sel;
        logic [PD_W-1:0]                div;
        logic [fmn_pkg::FMN_MODE_W-1:0] mode;
        logic [MN_W-1:0]                m;
        logic [MN_W-1:0]                n_code;
        logic [MN_W-1:0]                d_code;
    } act_cfg_t;

    act_cfg_t            act;
    logic                src_hit;
    logic                pre_tick;
    logic [PD_W+1:0]     pd_acc;
    logic [PD_W-1:0]     pd_div;
    fmn_pkg::mn_status_t mn_st;
    logic [MN_W:0]       mn_acc;
    logic [MN_W-1:0]     mn_ndec;
    logic                mn_on;
    logic                tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else if (cfg_load) begin
            act.sel    <= cfg_src_sel;
            act.div    <= cfg_pre_div;
            act.mode   <= cfg_mode;
            act.m      <= cfg_m;
            act.n_code <= cfg_n_code;
            act.d_code <= cfg_d_code;
        end
    end

    fmn_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .src_en (src_en),
        .sel    (act.sel),
        .hit    (src_hit)
    );

    fmn_prediv #(.PD_W(PD_W)) u_prediv (
        .clk      (clk),
        .rst      (rst),
        .clear    (cfg_load),
        .tick_in  (src_hit),
        .div      (act.div),
        .tick_out (pre_tick),
        .acc_o    (pd_acc)
    );

    fmn_mn_stage #(.MN_W(MN_W)) u_mn (
        .clk     (clk),
        .rst     (rst),
        .clear   (cfg_load),
        .tick_in (pre_tick),
        .mode    (act.mode),
        .m_val   (act.m),
        .n_code  (act.n_code),
        .d_code  (act.d_code),
        .status  (mn_st),
        .acc_o   (mn_acc),
        .n_dec_o (mn_ndec)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_load) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= mn_st.pulse;
        end
    end

    assign mn_on    = mn_st.active;
    assign pd_div   = act.div;
    assign tick_out = tick_q;
    assign duty_out = mn_on ? mn_st.duty : tick_q;
endmodule

// File: rtl/fmn_clken_gen_chk.sv
`timescale 1ns/1ps
module fmn_clken_gen_chk #(
    parameter int unsigned PD_W = fmn_pkg::FMN_PD_W_DEF,
    parameter int unsigned MN_W = fmn_pkg::FMN_MN_W_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_load,
    input logic            src_hit,
    input logic            tick_out,
    input logic            mn_on,
    input logic [MN_W:0]   mn_acc,
    input logic [MN_W-1:0] mn_ndec,
    input logic [PD_W+1:0] pd_acc,
    input logic [PD_W-1:0] pd_div
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tick_out);

    assert_load_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_load) |-> !tick_out);

    assert_tick_cause_R10: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(src_hit));

    assert_mn_bound_R6: assert property (@(posedge clk) disable iff (rst)
        mn_on |-> (mn_acc < {1'b0, mn_ndec}));

    assert_prediv_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (pd_div != '0) |-> (pd_acc <= {2'b00, pd_div}));
endmodule

bind fmn_clken_gen fmn_clken_gen_chk #(.PD_W(PD_W), .MN_W(MN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .src_hit  (src_hit),
    .tick_out (tick_out),
    .mn_on    (mn_on),
    .mn_acc   (mn_acc),
    .mn_ndec  (mn_ndec),
    .pd_acc   (pd_acc),
    .pd_div   (pd_div)
);

// File: tb/fmn_clken_gen_test.sv
`timescale 1ns/1ps
module fmn_clken_gen_test;
    localparam int NSRC = 8;
    localparam int PDW  = 3;
    localparam int MNW  = 4;
    localparam int MASK = (1 << MNW) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_en = '0;
    logic            cfg_load = 1'b0;
    logic [2:0]      cfg_src_sel = '0;
    logic [PDW-1:0]  cfg_pre_div = '0;
    logic [1:0]      cfg_mode = '0;
    logic [MNW-1:0]  cfg_m = '0;
    logic [MNW-1:0]  cfg_n_code = '0;
    logic [MNW-1:0]  cfg_d_code = '0;
    logic            tick_out;
    logic            duty_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fmn_clken_gen #(.NUM_SRC(NSRC), .PD_W(PDW), .MN_W(MNW)) uut (
        .clk(clk), .rst(rst), .src_en(src_en), .cfg_load(cfg_load),
        .cfg_src_sel(cfg_src_sel), .cfg_pre_div(cfg_pre_div), .cfg_mode(cfg_mode),
        .cfg_m(cfg_m), .cfg_n_code(cfg_n_code), .cfg_d_code(cfg_d_code),
        .tick_out(tick_out), .duty_out(duty_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NSRC-1:0] others_high(input int sel);
        return ~(NSRC'(1) << sel);
    endfunction

    // Load with true N and D values, encoded as software would write them
    task automatic load(input int sel, input int div, input int mode,
                        input int m, input int n_true, input int d_true);
        cfg_src_sel = 3'(sel);
        cfg_pre_div = PDW'(div);
        cfg_mode    = 2'(mode);
        cfg_m       = MNW'(m);
        cfg_n_code  = MNW'(~(n_true - m) & MASK);
        cfg_d_code  = MNW'(~d_true & MASK);
        src_en      = others_high(sel);
        cfg_load    = 1'b1;
        @(negedge clk);
        cfg_load    = 1'b0;
    endtask

    // K source ticks on the selected input; returns output pulse count
    task automatic run(input int sel, input int k, input string req, output int cnt);
        cnt = 0;
        for (int i = 0; i < k; i++) begin
            src_en = '1;
            @(negedge clk);
            if (tick_out) cnt++;
            if (!uut.mn_on) chk(duty_out == tick_out, "R8 bypass duty", duty_out, tick_out);
            src_en = others_high(sel);
            @(negedge clk);
            chk(tick_out == 1'b0, {req, " R10 single-cycle pulse"}, tick_out, 0);
        end
    endtask

    function automatic int exp_pre(input int div, input int k);
        return (div == 0) ? k : (2 * k) / (div + 1);
    endfunction

    function automatic int exp_out(input int q, input int mode, input int m, input int n_true);
        int nd;
        nd = n_true & MASK;
        if (mode != 0 && nd != 0 && m < nd) return (q * m) / nd;
        return q;
    endfunction

    initial begin
        int cnt;
        int e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tick_out == 1'b0, "R1 tick after reset", tick_out, 0);
        chk(duty_out == 1'b0, "R1 duty after reset", duty_out, 0);
        // default config after reset: source 0, no division
        run(0, 5, "R1", cnt);
        chk(cnt == 5, "R1 default config passes source 0", cnt, 5);

        // R2 / R3 / R4: every source against every pre-divider value
        for (int s = 0; s < NSRC; s++) begin
            for (int d = 0; d < (1 << PDW); d++) begin
                load(s, d, 0, 0, 0, 0);
                run(s, 13, "R2", cnt);
                e = exp_pre(d, 13);
                if (d == 0) chk(cnt == e, "R3 bypass count", cnt, e);
                else        chk(cnt == e, "R4 half-integer count", cnt, e);
            end
        end
        // R2: non-selected sources alone produce nothing
        load(5, 0, 0, 0, 0, 0);
        src_en = others_high(5);
        repeat (6) @(negedge clk);
        chk(tick_out == 1'b0, "R2 other sources ignored", tick_out, 0);

        // R5 / R6 / R7: every M against every true N in 1..15
        for (int n = 1; n <= MASK; n++) begin
            for (int m = 0; m <= MASK; m++) begin
                load(3, 0, 2, m, n, 0);
                run(3, 2 * n + 1, "R6", cnt);
                e = exp_out(2 * n + 1, 2, m, n);
                if (m < n) chk(cnt == e, "R5 R6 fractional count", cnt, e);
                else       chk(cnt == e, "R7 M>=N bypass count", cnt, e);
            end
        end
        // R7: mode 0 with a valid ratio
        load(2, 0, 0, 3, 7, 0);
        run(2, 14, "R7", cnt);
        chk(cnt == 14, "R7 mode zero bypass", cnt, 14);
        // R6: mode 1 also enables the stage
        load(2, 0, 1, 2, 5, 0);
        run(2, 15, "R6", cnt);
        chk(cnt == 6, "R6 mode one active", cnt, 6);
        // R7: true N decoding to zero
        load(2, 0, 2, 4, 16, 0);
        run(2, 9, "R7", cnt);
        chk(cnt == 9, "R7 zero N bypass", cnt, 9);
        // R4 + R6 combined
        load(6, 2, 2, 3, 7, 0);
        run(6, 30, "R4", cnt);
        chk(cnt == 8, "R4 R6 combined chain", cnt, 8);

        // R8: duty threshold trace M=3 N=10 D=5
        load(1, 0, 2, 3, 10, 5);
        chk(duty_out == 1'b1, "R8 duty at remainder 0", duty_out, 1);
        begin
            int exp_d [4] = '{1, 0, 0, 1};
            int exp_t [4] = '{0, 0, 0, 1};
            for (int i = 0; i < 4; i++) begin
                src_en = '1;
                @(negedge clk);
                chk(duty_out == exp_d[i][0], "R8 duty trace", duty_out, exp_d[i]);
                chk(tick_out == exp_t[i][0], "R10 tick trace", tick_out, exp_t[i]);
                src_en = others_high(1);
                @(negedge clk);
            end
        end
        // R9: load mid-accumulation restarts remainder (duty high again)
        load(1, 0, 2, 3, 10, 5);
        src_en = '1; @(negedge clk); src_en = others_high(1); @(negedge clk);
        src_en = '1; @(negedge clk); src_en = others_high(1); @(negedge clk);
        chk(duty_out == 1'b0, "R8 duty low at remainder 6", duty_out, 0);
        load(1, 0, 2, 3, 10, 5);
        chk(duty_out == 1'b1, "R9 load clears remainder", duty_out, 1);
        // R8: D = 0 keeps duty low
        load(1, 0, 2, 3, 10, 0);
        chk(duty_out == 1'b0, "R8 zero D duty low", duty_out, 0);

        // R9: source tick coincident with load is ignored
        cfg_src_sel = 3'd4; cfg_pre_div = '0; cfg_mode = '0;
        cfg_m = '0; cfg_n_code = '0; cfg_d_code = '0;
        src_en = '1; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(tick_out == 1'b0, "R9 coincident tick ignored", tick_out, 0);
        src_en = others_high(4);
        @(negedge clk);
        chk(tick_out == 1'b0, "R9 no delayed pulse", tick_out, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule